// File: doc/BRIEF.md
# Scan Output Byte Serializer

This block turns bytes written by a host into a bit stream on one scan-control or scan-data line of a boundary-scan master, such as the mode-select or data-out line. The host writes bytes over a narrow parallel port. Two byte registers alternate, so one register can be refilled while the other is being shifted. Bits leave each byte starting at bit 0. A shift happens on a clock cycle only when the output is enabled and the test-clock enable is high.

Before a scan, the host loads a length counter with the total number of bits to send. The counter steps down once per shifted bit and stops the scan at zero. Because of this counter, a scan does not have to be a multiple of eight bits. The meaningful bits of a short final byte go in its low-order positions. When the length counter reaches zero, the current register is released even if it still holds unsent bits. Those upper bits are never sent, and the next scan starts at bit 0 of the other register.

Top module: `scan_out_serializer`

## Requirements
- R1: After a synchronous reset, `ser_out` is 1, `empty` is 1, `full` is 0 and `len_tc` is 0.
- R2: Each byte is sent least significant bit first. Bit k of the byte appears on `ser_out` at the k-th shift of that register.
- R3: When both registers hold data and both enables stay high, the two bytes go out on consecutive cycles with no gap: 16 bits in 16 cycles.
- R4: A write while neither register holds data makes `empty` 0. A second write makes `full` 1. A write while `full` is 1 is ignored and never reaches `ser_out`, and `full` and `empty` are never both 1.
- R5: A shift happens only on a cycle where all of the following hold: `out_en` is 1, `tck_en` is 1, `empty` is 0, and the remaining length is nonzero. On any other cycle with `out_en` high, `ser_out` holds its value and the length does not change.
- R6: While `out_en` is 0, `ser_out` is driven to 1 starting from the next cycle.
- R7: Loading the length counter with N (`len_load` high for one cycle) results in exactly N shifted bits. `len_tc` is 1 for exactly the one cycle in which the N-th bit first shows on `ser_out`.
- R8: When the length counter reaches zero in the middle of a byte, that register is released. Its remaining upper bits are never sent, and the next shift sends bit 0 of the other register.
- R9: After the eighth shift of a register, that register is released and shifting continues at bit 0 of the other register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Byte to store; meaningful bits in the low positions |
| len_load | input | 1 | Load the scan length counter |
| len_value | input | 32 | Number of bits to send in the scan |
| out_en | input | 1 | Output line enable |
| tck_en | input | 1 | Test clock enable; one shift per enabled cycle |
| ser_out | output | 1 | Registered serial output line |
| full | output | 1 | Both byte registers hold data |
| empty | output | 1 | No byte register holds data |
| len_tc | output | 1 | One-cycle pulse with the final bit of a scan |

## Verification
A write or a length load takes effect at the rising edge where it is sampled, so `full` and `empty` change right after that edge. A shift decided at an edge puts its bit on `ser_out` right after that same edge, and `len_tc` rises with the final bit. Shifting can start at the first edge after the length load. The bench drives inputs 1 ns after a rising edge and samples results 1 ns after each following edge. It compares each sampled bit with a bit vector worked out by hand from the written bytes and the loaded length, and it tests `len_tc` against the index of the final bit.

// File: rtl/sos_pkg.sv
package sos_pkg;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 32;
  localparam int NUM_REGS = 2;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/sos_len_counter.sv
module sos_len_counter #(
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             dec,
  output logic             active,
  output logic             last
);
  logic [LEN_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (dec && active) begin
      remain <= remain - 1'b1;
    end
  end

  assign active = (remain != '0);
  assign last   = (remain == LEN_W'(1));
endmodule

// File: rtl/sos_bit_counter.sv
module sos_bit_counter #(
  parameter int BYTE_W = 8,
  localparam int IDX_W = $clog2(BYTE_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             clr,
  output logic [IDX_W-1:0] idx,
  output logic             at_end
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idx <= '0;
    end else if (adv) begin
      idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
    end
  end

  assign at_end = (idx == LAST_IDX);
endmodule

// File: rtl/sos_byte_store.sv
module sos_byte_store
  import sos_pkg::*;
#(
  parameter int BYTE_W = sos_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              release_cur,
  output logic [BYTE_W-1:0] cur_byte,
  output logic              empty,
  output logic              full
);
  logic [BYTE_W-1:0] slot_data [NUM_REGS];
  logic [NUM_REGS-1:0] slot_vld;
  logic sel;
  logic wr_idx;
  logic accept;

  assign full   = &slot_vld;
  assign empty  = ~slot_vld[sel];
  assign wr_idx = slot_vld[sel] ? ~sel : sel;
  assign accept = wr_en && !full;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (accept && (wr_idx == g[0])) begin
        slot_data[g] <= wr_data;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        slot_vld[g] <= 1'b0;
      end else if (accept && (wr_idx == g[0])) begin
        slot_vld[g] <= 1'b1;
      end else if (release_cur && (sel == g[0])) begin
        slot_vld[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel <= 1'b0;
    end else if (release_cur) begin
      sel <= ~sel;
    end
  end

  assign cur_byte = slot_data[sel];
endmodule

// File: rtl/scan_out_serializer.sv
module scan_out_serializer
  import sos_pkg::*;
#(
  parameter int BYTE_W = sos_pkg::BYTE_W,
  parameter int LEN_W  = sos_pkg::LEN_W,
  localparam int IDX_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              len_load,
  input  logic [LEN_W-1:0]  len_value,
  input  logic              out_en,
  input  logic              tck_en,
  output logic              ser_out,
  output logic              full,
  output logic              empty,
  output logic              len_tc
);
  logic [BYTE_W-1:0] cur_byte;
  logic [IDX_W-1:0]  bit_idx;
  logic byte_done;
  logic len_active;
  logic len_last;
  logic shift_go;
  logic release_cur;

  assign shift_go    = out_en && tck_en && !empty && len_active;
  assign release_cur = shift_go && (byte_done || len_last);

  sos_byte_store #(.BYTE_W(BYTE_W)) u_store (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .release_cur(release_cur),
    .cur_byte   (cur_byte),
    .empty      (empty),
    .full       (full)
  );

  sos_bit_counter #(.BYTE_W(BYTE_W)) u_bits (
    .clk   (clk),
    .rst   (rst),
    .adv   (shift_go),
    .clr   (release_cur),
    .idx   (bit_idx),
    .at_end(byte_done)
  );

  sos_len_counter #(.LEN_W(LEN_W)) u_len (
    .clk     (clk),
    .rst     (rst),
    .load    (len_load),
    .load_val(len_value),
    .dec     (shift_go),
    .active  (len_active),
    .last    (len_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_out <= 1'b1;
      len_tc  <= 1'b0;
    end else begin
      len_tc <= shift_go && len_last && !len_load;
      if (!out_en) begin
        ser_out <= 1'b1;
      end else if (shift_go) begin
        ser_out <= cur_byte[bit_idx];
      end
    end
  end
endmodule

// File: rtl/sos_checker.sv
module sos_checker (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic len_load,
  input logic out_en,
  input logic tck_en,
  input logic ser_out,
  input logic full,
  input logic empty,
  input logic len_tc
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (ser_out && empty && !full && !len_tc));

  assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  assert_full_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (full && !(out_en && tck_en)) |=> full);

  assert_empty_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (empty && !wr_en) |=> empty);

  assert_hold_no_tck_R5: assert property (@(posedge clk) disable iff (rst)
    (out_en && !tck_en) |=> $stable(ser_out));

  assert_idle_high_R6: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> ser_out);

  assert_tc_after_shift_R7: assert property (@(posedge clk) disable iff (rst)
    (!(out_en && tck_en && !empty)) |=> !len_tc);
endmodule

bind scan_out_serializer sos_checker u_sos_checker (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .len_load(len_load),
  .out_en  (out_en),
  .tck_en  (tck_en),
  .ser_out (ser_out),
  .full    (full),
  .empty   (empty),
  .len_tc  (len_tc)
);

// File: tb/tb_scan_out_serializer.sv
`timescale 1ns/1ps
module tb_scan_out_serializer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic len_load = 1'b0;
  logic [31:0] len_value = '0;
  logic out_en = 1'b0;
  logic tck_en = 1'b0;
  logic ser_out, full, empty, len_tc;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  scan_out_serializer dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .len_load(len_load), .len_value(len_value), .out_en(out_en),
    .tck_en(tck_en), .ser_out(ser_out), .full(full), .empty(empty),
    .len_tc(len_tc)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 0; len_load = 0; out_en = 0; tck_en = 0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic write_byte(logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic load_len(int n);
    len_load = 1'b1; len_value = n;
    tick();
    len_load = 1'b0;
  endtask

  // enables high for n cycles; bit i of exp expected on the i-th sample
  task automatic run_bits(string req, int n, logic [63:0] exp);
    out_en = 1'b1; tck_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      tick();
      check(req, $sformatf("bit %0d", i), int'(ser_out), int'(exp[i]));
      check("R7", $sformatf("len_tc at bit %0d", i), int'(len_tc), (i == n-1) ? 1 : 0);
    end
    tck_en = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "ser_out", ser_out, 1);
    check("R1", "empty", empty, 1);
    check("R1", "full", full, 0);
    check("R1", "len_tc", len_tc, 0);
  endtask

  task automatic t_partial_three();
    do_reset();
    write_byte(8'hFB);
    load_len(3);
    run_bits("R2", 3, 64'b011);
    check("R8", "empty after tc", empty, 1);
    tick();
    check("R7", "len_tc one cycle", len_tc, 0);
    tck_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      check("R8", "upper bits not sent", ser_out, 0);
    end
    tck_en = 1'b0;
  endtask

  task automatic t_double_buffer();
    do_reset();
    write_byte(8'hA5);
    check("R4", "empty after 1st write", empty, 0);
    check("R4", "full after 1st write", full, 0);
    write_byte(8'h3C);
    check("R4", "full after 2nd write", full, 1);
    write_byte(8'hFF);
    check("R4", "full after ignored write", full, 1);
    load_len(16);
    run_bits("R3", 16, {48'h0, 8'h3C, 8'hA5});
    check("R9", "empty after 16 bits", empty, 1);
    load_len(8);
    tck_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick();
      check("R4", "ignored byte not sent", ser_out, 0);
      check("R4", "no tc with empty store", len_tc, 0);
    end
    tck_en = 1'b0;
  endtask

  task automatic t_tc_switch();
    do_reset();
    write_byte(8'h0D);
    write_byte(8'h96);
    load_len(3);
    run_bits("R8", 3, 64'b101);
    check("R8", "full after partial release", full, 0);
    check("R8", "empty after partial release", empty, 0);
    load_len(8);
    run_bits("R8", 8, 64'h96);
    check("R9", "empty at end", empty, 1);
  endtask

  task automatic t_gating();
    do_reset();
    write_byte(8'h00);
    load_len(8);
    out_en = 1'b1; tck_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R5", "hold without tck_en", ser_out, 1);
      check("R5", "no tc without tck_en", len_tc, 0);
    end
    tck_en = 1'b1;
    tick(); check("R5", "bit 0", ser_out, 0);
    tick(); check("R5", "bit 1", ser_out, 0);
    out_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R6", "idle high when disabled", ser_out, 1);
      check("R5", "no tc when disabled", len_tc, 0);
    end
    run_bits("R5", 6, 64'h0);
  endtask

  task automatic t_len_ten();
    do_reset();
    write_byte(8'hFF);
    write_byte(8'h02);
    load_len(10);
    run_bits("R9", 10, {54'h0, 2'b10, 8'hFF});
    check("R7", "empty after 10 bits", empty, 1);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_partial_three();
    t_double_buffer();
    t_tc_switch();
    t_gating();
    t_len_ten();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule